// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of which parts of a small on-chip packet memory are in use. The memory is divided into 256-byte pages and every stored packet is identified by a packet number drawn from a fixed pool. A host drives one command at a time through a command port. It can ask for a number of pages, hand a packet to the transmit queue, release the packet at the head of the receive queue, free a named packet, or wipe the whole pool. The data RAM is not modelled. Only the ownership of each page by a packet number is stored.

An allocation request carries the page count minus one, so zero pages cannot be requested. The outcome is a packet number plus a failed flag, and an allocation interrupt status bit is raised in either case. The receive side pushes the numbers of received packets into a FIFO whose head and empty flag the host can see. The transmit side pops its queue on every completion signal from the MAC. If automatic release is enabled, a packet that was sent without error gives back its pages with no host action. Transmit-complete and transmit-queue-empty status bits record these events. Every status bit is cleared by writing a one to its acknowledge input.

Top module: `pkt_buf_alloc`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the outputs read as follows: busy=0, alloc_pkt=0, alloc_failed=0, int_status=0, rx_empty=1, tx_head_valid=0, and free_pages equal to PAGES.
- R2: A command is accepted on a clock edge where cmd_valid=1 and busy=0. busy reads 1 for exactly the next cycle, and the command's effects are visible after the edge that ends that cycle. A cmd_valid seen while busy=1 is ignored.
- R3: ALLOC (cmd_op=1) with cmd_arg=k takes the k+1 lowest-numbered free pages and gives them to the lowest-numbered packet number not in use. That packet number appears on alloc_pkt, alloc_failed goes to 0, and free_pages drops by k+1.
- R4: If no packet number is unused, or fewer than k+1 pages are free, ALLOC sets alloc_failed=1. Page ownership and alloc_pkt stay as they were.
- R5: Every completed ALLOC sets int_status[0], whether it succeeded or failed. Each int_status bit clears on a cycle where the matching int_ack bit is 1, unless the same cycle sets that bit again.
- R6: rx_in_valid pushes rx_in_pkt into a receive FIFO of SLOTS entries. A push into a full FIFO is dropped. rx_empty and rx_head_pkt show the state of the FIFO. RXREL (cmd_op=3) frees the pages of the head packet and pops it. RXREL on an empty FIFO has no effect.
- R7: ENQ (cmd_op=4) appends cmd_pkt to the transmit queue, and tx_head_valid/tx_head_pkt show the oldest entry.
- R8: tx_done=1 while the queue is non-empty pops the head and sets int_status[1]. If the queue is then empty, it also sets int_status[2]. tx_done with an empty queue is ignored.
- R9: On a pop, the popped packet's pages are freed only when auto_release=1 and tx_ok=1. Otherwise they stay owned.
- R10: FREE (cmd_op=5) frees every page owned by cmd_pkt and returns that packet number to the pool. FREE on an unused number changes nothing.
- R11: RESET (cmd_op=2) frees all pages and all packet numbers and empties both queues. int_status, alloc_pkt and alloc_failed are kept. Op codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | ARG_W | Page count minus one for ALLOC |
| cmd_pkt | input | SW | Packet number for ENQ and FREE |
| busy | output | 1 | Command executing |
| alloc_pkt | output | SW | Last packet number granted |
| alloc_failed | output | 1 | Last allocation found no room |
| int_ack | input | 3 | Write-one-to-clear for int_status |
| int_status | output | 3 | [0] alloc done, [1] tx complete, [2] tx queue empty |
| auto_release | input | 1 | Free packets sent without error |
| rx_in_valid | input | 1 | Received packet number strobe |
| rx_in_pkt | input | SW | Received packet number |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_head_pkt | output | SW | Receive FIFO head |
| tx_done | input | 1 | MAC finished the head packet |
| tx_ok | input | 1 | That transmission had no error |
| tx_head_valid | output | 1 | Transmit queue not empty |
| tx_head_pkt | output | SW | Transmit queue head |
| free_pages | output | CW | Count of unowned pages |

## Verification
The hardest cases to reach from the ports are events that land on the same edge. Examples are a transmit completion with auto-release in the cycle that commits an allocation or a RESET, a receive push into a FIFO that is popping or full, and an ENQ on the edge where the last queued packet drains, which must keep the empty status bit clear. A directed phase first walks through each command and boundary with known values. A long phase then drives random commands (including ones held high while busy), random receive pushes, random completions and random acknowledges on every cycle. That makes these overlaps happen often, and a queue-based model compares all outputs each cycle.

// File: rtl/pba_pkg.sv
package pba_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ALLOC = 3'd1,
        OP_RESET = 3'd2,
        OP_RXREL = 3'd3,
        OP_ENQ   = 3'd4,
        OP_FREE  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    localparam int INT_ALLOC = 0;
    localparam int INT_TX    = 1;
    localparam int INT_TXE   = 2;
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          empty,
    output logic [DW-1:0] head,
    output logic          drained
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd;
        logic [AW-1:0]            wr;
        logic [AW:0]              cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic push_ok, pop_ok;

    always_comb begin
        d       = q;
        push_ok = push && (q.cnt != (AW+1)'(DEPTH));
        pop_ok  = pop && (q.cnt != '0);
        if (push_ok) begin
            d.mem[q.wr] = push_data;
            d.wr        = q.wr + 1'b1;
        end
        if (pop_ok) begin
            d.rd = q.rd + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (clear) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end
        drained = pop_ok && (d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign empty = (q.cnt == '0);
    assign head  = q.mem[q.rd];
endmodule

// File: rtl/pba_page_pool.sv
module pba_page_pool #(
    parameter int PAGES = 16,
    parameter int SLOTS = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int CW   = $clog2(PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          alloc_req,
    input  logic [CW-1:0] need,
    input  logic          free_a_vld,
    input  logic [SW-1:0] free_a_pkt,
    input  logic          free_b_vld,
    input  logic [SW-1:0] free_b_pkt,
    output logic          alloc_ok,
    output logic [SW-1:0] alloc_slot,
    output logic [CW-1:0] free_cnt
);
    typedef struct packed {
        logic [SLOTS-1:0]            used;
        logic [SLOTS-1:0][PAGES-1:0] own;
    } pool_st_t;

    pool_st_t         q, d;
    logic [PAGES-1:0] taken;
    logic [PAGES-1:0] free_mask;
    logic [PAGES-1:0] grant;
    logic [CW-1:0]    picked;
    logic             slot_found;

    always_comb begin
        taken = '0;
        for (int s = 0; s < SLOTS; s++) begin
            taken = taken | q.own[s];
        end
        free_mask = ~taken;

        free_cnt = '0;
        for (int i = 0; i < PAGES; i++) begin
            free_cnt = free_cnt + CW'(free_mask[i]);
        end

        slot_found = 1'b0;
        alloc_slot = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!slot_found && !q.used[s]) begin
                slot_found = 1'b1;
                alloc_slot = SW'(s);
            end
        end

        grant  = '0;
        picked = '0;
        for (int i = 0; i < PAGES; i++) begin
            if (free_mask[i] && (picked < need)) begin
                grant[i] = 1'b1;
                picked   = picked + 1'b1;
            end
        end

        alloc_ok = slot_found && (free_cnt >= need);
    end

    always_comb begin
        d = q;
        if (free_a_vld) begin
            d.used[free_a_pkt] = 1'b0;
            d.own[free_a_pkt]  = '0;
        end
        if (free_b_vld) begin
            d.used[free_b_pkt] = 1'b0;
            d.own[free_b_pkt]  = '0;
        end
        if (alloc_req && alloc_ok) begin
            d.used[alloc_slot] = 1'b1;
            d.own[alloc_slot]  = grant;
        end
        if (clear) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pkt_buf_alloc.sv
module pkt_buf_alloc
    import pba_pkg::*;
#(
    parameter int PAGES = 16,
    parameter int SLOTS = 8,
    parameter int ARG_W = 3,
    localparam int SW   = $clog2(SLOTS),
    localparam int CW   = $clog2(PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic [SW-1:0]    cmd_pkt,
    output logic             busy,
    output logic [SW-1:0]    alloc_pkt,
    output logic             alloc_failed,
    input  logic [2:0]       int_ack,
    output logic [2:0]       int_status,
    input  logic             auto_release,
    input  logic             rx_in_valid,
    input  logic [SW-1:0]    rx_in_pkt,
    output logic             rx_empty,
    output logic [SW-1:0]    rx_head_pkt,
    input  logic             tx_done,
    input  logic             tx_ok,
    output logic             tx_head_valid,
    output logic [SW-1:0]    tx_head_pkt,
    output logic [CW-1:0]    free_pages
);
    typedef struct packed {
        logic             busy;
        op_e              op;
        logic [ARG_W-1:0] arg;
        logic [SW-1:0]    pkt;
        logic [SW-1:0]    apkt;
        logic             afail;
        logic [2:0]       ints;
    } ctl_st_t;

    ctl_st_t       q, d;

    logic          do_alloc, do_reset, do_rxrel, do_enq, do_free;
    logic [CW-1:0] need;
    logic          alloc_ok;
    logic [SW-1:0] alloc_slot;
    logic          free_a_vld;
    logic [SW-1:0] free_a_pkt;
    logic          free_b_vld;
    logic          tx_empty;
    logic          tx_pop_ok;
    logic          tx_drained;
    logic          rx_drained;

    always_comb begin
        do_alloc   = q.busy && (q.op == OP_ALLOC);
        do_reset   = q.busy && (q.op == OP_RESET);
        do_rxrel   = q.busy && (q.op == OP_RXREL);
        do_enq     = q.busy && (q.op == OP_ENQ);
        do_free    = q.busy && (q.op == OP_FREE);
        need       = CW'(q.arg) + 1'b1;
        free_a_vld = do_free || (do_rxrel && !rx_empty);
        free_a_pkt = do_free ? q.pkt : rx_head_pkt;
        tx_pop_ok  = tx_done && !tx_empty;
        free_b_vld = tx_pop_ok && auto_release && tx_ok;
    end

    always_comb begin
        d      = q;
        d.ints = q.ints & ~int_ack;
        d.busy = 1'b0;
        if (!q.busy && cmd_valid) begin
            d.busy = 1'b1;
            d.op   = op_e'(cmd_op);
            d.arg  = cmd_arg;
            d.pkt  = cmd_pkt;
        end
        if (do_alloc) begin
            d.ints[INT_ALLOC] = 1'b1;
            d.afail           = !alloc_ok;
            if (alloc_ok) begin
                d.apkt = alloc_slot;
            end
        end
        if (tx_pop_ok) begin
            d.ints[INT_TX] = 1'b1;
        end
        if (tx_drained) begin
            d.ints[INT_TXE] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, op: OP_NOP, default: '0};
        end else begin
            q <= d;
        end
    end

    pba_page_pool #(
        .PAGES (PAGES),
        .SLOTS (SLOTS)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (do_reset),
        .alloc_req  (do_alloc),
        .need       (need),
        .free_a_vld (free_a_vld),
        .free_a_pkt (free_a_pkt),
        .free_b_vld (free_b_vld),
        .free_b_pkt (tx_head_pkt),
        .alloc_ok   (alloc_ok),
        .alloc_slot (alloc_slot),
        .free_cnt   (free_pages)
    );

    pba_fifo #(
        .DEPTH (SLOTS),
        .DW    (SW)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_reset),
        .push      (rx_in_valid),
        .push_data (rx_in_pkt),
        .pop       (do_rxrel),
        .empty     (rx_empty),
        .head      (rx_head_pkt),
        .drained   (rx_drained)
    );

    pba_fifo #(
        .DEPTH (SLOTS),
        .DW    (SW)
    ) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_reset),
        .push      (do_enq),
        .push_data (q.pkt),
        .pop       (tx_done),
        .empty     (tx_empty),
        .head      (tx_head_pkt),
        .drained   (tx_drained)
    );

    assign busy          = q.busy;
    assign alloc_pkt     = q.apkt;
    assign alloc_failed  = q.afail;
    assign int_status    = q.ints;
    assign tx_head_valid = !tx_empty;
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cmd_valid,
    input logic [CW-1:0] free_pages,
    input logic          alloc_failed,
    input logic          tx_done,
    input logic          auto_release,
    input logic [2:0]    int_status,
    input logic [2:0]    int_ack,
    input logic          tx_head_valid,
    input logic          rx_drained,
    input logic          rx_empty
);
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy); // R2
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R2
    AST_IDLE_PAGES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(tx_done && auto_release)) |=> $stable(free_pages)); // R2
    AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(alloc_failed) && !$past(tx_done)) |-> $stable(free_pages)); // R4
    AST_ACK_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (int_status[0] && int_ack[0] && !busy) |=> !int_status[0]); // R5
    AST_TXE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_status[2]) |-> !tx_head_valid); // R8
    AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drained |=> rx_empty); // R6
endmodule

bind pkt_buf_alloc pba_checker #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .cmd_valid     (cmd_valid),
    .free_pages    (free_pages),
    .alloc_failed  (alloc_failed),
    .tx_done       (tx_done),
    .auto_release  (auto_release),
    .int_status    (int_status),
    .int_ack       (int_ack),
    .tx_head_valid (tx_head_valid),
    .rx_drained    (rx_drained),
    .rx_empty      (rx_empty)
);

// File: tb/test_pkt_buf_alloc.sv
`timescale 1ns/1ps
module test_pkt_buf_alloc;
    localparam int P  = 16;
    localparam int S  = 8;
    localparam int SW = 3;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [2:0]    cmd_arg = '0;
    logic [SW-1:0] cmd_pkt = '0;
    logic          busy;
    logic [SW-1:0] alloc_pkt;
    logic          alloc_failed;
    logic [2:0]    int_ack = '0;
    logic [2:0]    int_status;
    logic          auto_release = 1'b1;
    logic          rx_in_valid = 1'b0;
    logic [SW-1:0] rx_in_pkt = '0;
    logic          rx_empty;
    logic [SW-1:0] rx_head_pkt;
    logic          tx_done = 1'b0;
    logic          tx_ok = 1'b0;
    logic          tx_head_valid;
    logic [SW-1:0] tx_head_pkt;
    logic [CW-1:0] free_pages;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pkt_buf_alloc i_pkt_buf_alloc (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_pkt(cmd_pkt), .busy(busy), .alloc_pkt(alloc_pkt),
        .alloc_failed(alloc_failed), .int_ack(int_ack), .int_status(int_status),
        .auto_release(auto_release), .rx_in_valid(rx_in_valid), .rx_in_pkt(rx_in_pkt),
        .rx_empty(rx_empty), .rx_head_pkt(rx_head_pkt), .tx_done(tx_done), .tx_ok(tx_ok),
        .tx_head_valid(tx_head_valid), .tx_head_pkt(tx_head_pkt), .free_pages(free_pages)
    );

    // behavioural reference model
    int  m_own [P];
    bit  m_used [S];
    int  m_rxq [$];
    int  m_txq [$];
    bit  m_busy;
    int  m_op, m_arg, m_pkt;
    int  m_apkt;
    bit  m_afail;
    bit [2:0] m_int;

    task automatic m_clear_pool();
        for (int i = 0; i < P; i++) m_own[i] = -1;
        for (int s = 0; s < S; s++) m_used[s] = 0;
    endtask

    task automatic m_free(int pk);
        m_used[pk] = 0;
        for (int i = 0; i < P; i++) if (m_own[i] == pk) m_own[i] = -1;
    endtask

    function automatic int m_free_cnt();
        int c = 0;
        for (int i = 0; i < P; i++) if (m_own[i] < 0) c++;
        return c;
    endfunction

    always @(posedge clk) begin : model
        int  need, slot, got, pk;
        bit  ok, rx_push_ok, tx_pop_ok, tx_push_ok;
        bit [2:0] ni;
        if (!rst_n) begin
            m_clear_pool();
            m_rxq.delete();
            m_txq.delete();
            m_busy = 0; m_op = 0; m_arg = 0; m_pkt = 0;
            m_apkt = 0; m_afail = 0; m_int = 0;
        end else begin
            rx_push_ok = rx_in_valid && (m_rxq.size() < S);
            tx_pop_ok  = tx_done && (m_txq.size() > 0);
            tx_push_ok = m_busy && (m_op == 4) && (m_txq.size() < S);
            need = m_arg + 1;
            slot = -1;
            for (int s = S - 1; s >= 0; s--) if (!m_used[s]) slot = s;
            ok = (slot >= 0) && (m_free_cnt() >= need);
            ni = m_int & ~int_ack;
            if (tx_pop_ok) begin
                pk = m_txq.pop_front();
                if (auto_release && tx_ok) m_free(pk);
                ni[1] = 1;
            end
            if (m_busy && m_op == 3 && m_rxq.size() > 0) begin
                pk = m_rxq.pop_front();
                m_free(pk);
            end
            if (m_busy && m_op == 5) m_free(m_pkt);
            if (tx_push_ok) m_txq.push_back(m_pkt);
            if (rx_push_ok) m_rxq.push_back(int'(rx_in_pkt));
            if (m_busy && m_op == 1) begin
                ni[0] = 1;
                if (ok) begin
                    got = 0;
                    for (int i = 0; i < P; i++) begin
                        if (m_own[i] < 0 && got < need) begin
                            m_own[i] = slot;
                            got++;
                        end
                    end
                    m_used[slot] = 1;
                    m_apkt = slot;
                    m_afail = 0;
                end else begin
                    m_afail = 1;
                end
            end
            if (m_busy && m_op == 2) begin
                m_clear_pool();
                m_rxq.delete();
                m_txq.delete();
            end
            if (tx_pop_ok && m_txq.size() == 0) ni[2] = 1;
            m_int = ni;
            if (!m_busy && cmd_valid) begin
                m_busy = 1;
                m_op = int'(cmd_op); m_arg = int'(cmd_arg); m_pkt = int'(cmd_pkt);
            end else begin
                m_busy = 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2", "busy", int'(busy), int'(m_busy));
            chk("R3", "alloc_pkt", int'(alloc_pkt), m_apkt);
            chk("R4", "alloc_failed", int'(alloc_failed), int'(m_afail));
            chk("R5/R8", "int_status", int'(int_status), int'(m_int));
            chk("R3/R9", "free_pages", int'(free_pages), m_free_cnt());
            chk("R6", "rx_empty", int'(rx_empty), int'(m_rxq.size() == 0));
            if (m_rxq.size() > 0) chk("R6", "rx_head_pkt", int'(rx_head_pkt), m_rxq[0]);
            chk("R7", "tx_head_valid", int'(tx_head_valid), int'(m_txq.size() > 0));
            if (m_txq.size() > 0) chk("R7", "tx_head_pkt", int'(tx_head_pkt), m_txq[0]);
        end
    end

    task automatic issue(int op, int arg, int pk);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 3'(arg); cmd_pkt = 3'(pk);
        @(negedge clk);
        cmd_valid = 0;
        @(negedge clk);
    endtask

    task automatic pulse_tx(bit okv);
        @(negedge clk);
        tx_done = 1; tx_ok = okv;
        @(negedge clk);
        tx_done = 0; tx_ok = 0;
    endtask

    task automatic push_rx(int pk);
        @(negedge clk);
        rx_in_valid = 1; rx_in_pkt = 3'(pk);
        @(negedge clk);
        rx_in_valid = 0;
    endtask

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while held in reset
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "free_pages in reset", int'(free_pages), P);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "rx_empty", int'(rx_empty), 1);
        chk("R1", "tx_head_valid", int'(tx_head_valid), 0);
        chk("R1", "int_status", int'(int_status), 0);
        chk("R1", "alloc_failed", int'(alloc_failed), 0);

        issue(1, 3, 0);
        chk("R3", "first alloc pkt", int'(alloc_pkt), 0);
        chk("R3", "free after 4 pages", int'(free_pages), 12);
        chk("R5", "alloc int set", int'(int_status[0]), 1);
        @(negedge clk); int_ack = 3'b001;
        @(negedge clk); int_ack = 3'b000;
        chk("R5", "alloc int acked", int'(int_status[0]), 0);

        issue(1, 7, 0);
        chk("R3", "second alloc pkt", int'(alloc_pkt), 1);
        chk("R3", "free after 8 pages", int'(free_pages), 4);
        issue(1, 4, 0);
        chk("R4", "failed flag", int'(alloc_failed), 1);
        chk("R4", "pages kept", int'(free_pages), 4);
        chk("R4", "alloc_pkt kept", int'(alloc_pkt), 1);
        chk("R5", "int set on failure", int'(int_status[0]), 1);

        // R2: cmd_valid held while busy is ignored
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_arg = 3'd0;
        @(negedge clk);
        chk("R2", "busy after accept", int'(busy), 1);
        @(negedge clk);
        cmd_valid = 0;
        chk("R2", "single alloc only", int'(free_pages), 3);
        chk("R2", "granted pkt", int'(alloc_pkt), 2);
        @(negedge clk);
        chk("R2", "still one page taken", int'(free_pages), 3);

        issue(5, 0, 5);
        chk("R10", "free unused pkt", int'(free_pages), 3);
        issue(5, 0, 2);
        chk("R10", "free pkt 2", int'(free_pages), 4);

        issue(4, 0, 1);
        chk("R7", "tx head valid", int'(tx_head_valid), 1);
        chk("R7", "tx head pkt", int'(tx_head_pkt), 1);
        @(negedge clk); int_ack = 3'b111;
        @(negedge clk); int_ack = 3'b000;
        pulse_tx(1);
        chk("R9", "auto release frees", int'(free_pages), 12);
        chk("R8", "tx int", int'(int_status[1]), 1);
        chk("R8", "tx empty int", int'(int_status[2]), 1);
        chk("R8", "queue empty", int'(tx_head_valid), 0);

        auto_release = 0;
        issue(4, 0, 0);
        pulse_tx(1);
        chk("R9", "no release when disabled", int'(free_pages), 12);
        auto_release = 1;
        pulse_tx(1);
        chk("R8", "done on empty queue ignored", int'(free_pages), 12);

        push_rx(0);
        chk("R6", "rx not empty", int'(rx_empty), 0);
        chk("R6", "rx head", int'(rx_head_pkt), 0);
        issue(3, 0, 0);
        chk("R6", "release frees", int'(free_pages), 16);
        chk("R6", "rx empty after release", int'(rx_empty), 1);
        issue(3, 0, 0);
        chk("R6", "release on empty", int'(free_pages), 16);

        issue(1, 0, 0);
        issue(1, 1, 0);
        issue(4, 0, 0);
        push_rx(1);
        issue(2, 0, 0);
        chk("R11", "reset frees pages", int'(free_pages), 16);
        chk("R11", "reset empties rx", int'(rx_empty), 1);
        chk("R11", "reset empties tx", int'(tx_head_valid), 0);
        chk("R11", "alloc_pkt kept", int'(alloc_pkt), 1);
        issue(6, 0, 0);
        chk("R11", "reserved op", int'(free_pages), 16);

        // random phase, checked by the model every cycle
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            cmd_valid    = ($urandom_range(0, 2) == 0);
            cmd_op       = 3'($urandom_range(0, 7));
            if (cmd_op == 3'd2 && $urandom_range(0, 3) != 0) cmd_op = 3'd1;
            cmd_arg      = 3'($urandom_range(0, 7));
            cmd_pkt      = 3'($urandom_range(0, 7));
            rx_in_valid  = ($urandom_range(0, 3) == 0);
            rx_in_pkt    = 3'($urandom_range(0, 7));
            tx_done      = ($urandom_range(0, 3) == 0);
            tx_ok        = ($urandom_range(0, 3) != 0);
            int_ack      = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 31) == 0) auto_release = ~auto_release;
        end
        @(negedge clk);
        cmd_valid = 0; rx_in_valid = 0; tx_done = 0; int_ack = 0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule